// File: doc/BRIEF.md
# Bus Transfer Timeout Watchdog

This block guards a bus data transfer against a target that never finishes. The falling edge of the active-low data strobe arms it. While the strobe stays low, it counts falling edges of a slow timer clock that is not related to the system clock. If the configured number of those edges passes before the strobe goes high again, it raises a sticky fault flag. A strobe that returns high in time clears the count, and nothing is reported.

The timer clock is sampled through a synchronizer chain in the system clock domain, and its falling edges are found after that chain. After one expiry, the watchdog stays idle until the strobe has gone high and fallen again. Software or the surrounding logic removes the fault with a clear pulse.

Top module: `bus_xfer_wdog`

## Requirements
- R1: After reset, `fault_o` is 0.
- R2: A falling edge of `strobe_ni` (1 in one cycle, 0 in the next) arms the watchdog with its count at zero. A timer-clock edge detected in that same cycle is not counted.
- R3: While armed and `strobe_ni` is 0, each falling edge of `tclk_i` adds one to the count. An edge becomes visible to the count SYNC_STAGES system cycles after `tclk_i` is sampled low.
- R4: When the LIMIT-th counted edge (default 2) is seen with `strobe_ni` still 0, `fault_o` goes to 1 on the next clock edge.
- R5: A rising edge of `strobe_ni` disarms the watchdog and sets the count to zero. A later transfer then needs LIMIT fresh edges to fault.
- R6: Timer-clock edges that occur while `strobe_ni` is 1 have no effect.
- R7: If the strobe rises in the same cycle as the expiring edge, the transfer counts as complete and no fault is raised.
- R8: `fault_o` stays 1 until `clear_i` is 1 at a clock edge. A new expiry in that same cycle wins over the clear.
- R9: The count never exceeds LIMIT. After an expiry, no new count starts until the strobe has risen and fallen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_ni | input | 1 | Data strobe, active low, synchronous to clk_i |
| tclk_i | input | 1 | Slow timer clock, unsynchronized |
| clear_i | input | 1 | Clears the fault flag |
| fault_o | output | 1 | Sticky bus fault flag |

## Verification
A count that is not cleared when the strobe rises shows up at the ports on the next transfer: the fault appears one timer edge early. A count that restarts after an expiry shows up as a second fault after a clear, without any new strobe edge. An error in the synchronizer delay or in the tie-break with the strobe shifts the boundary of the release-offset sweep by one system cycle. The bench sees that change in `fault_o` two cycles after the coincident edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    WD_IDLE  = 2'd0,
    WD_ARMED = 2'd1,
    WD_SPENT = 2'd2
  } wd_state_e;
endpackage

// File: rtl/wdog_edge_sync.sv
module wdog_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign fall_o = last_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int LIMIT = 2,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             done_i,
  input  logic             low_i,
  input  logic             tick_i,
  output logic             expire_o,
  output logic [CNT_W-1:0] cnt_o,
  output wd_state_e        state_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  wd_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // a strobe rise implies low_i == 0, so completion beats expiry
  assign expire_o = (state_q == WD_ARMED) && low_i && !arm_i && tick_i && (cnt_q == LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (arm_i) begin
      state_d = WD_ARMED;
      cnt_d   = '0;
    end else if (done_i) begin
      state_d = WD_IDLE;
      cnt_d   = '0;
    end else if (state_q == WD_ARMED && low_i && tick_i) begin
      cnt_d = cnt_q + 1'b1;
      if (expire_o) state_d = WD_SPENT;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WD_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign state_o = state_q;
endmodule

// File: rtl/wdog_fault_flag.sv
module wdog_fault_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clear_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_o <= 1'b0;
    else if (set_i)   flag_o <= 1'b1;
    else if (clear_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/bus_xfer_wdog.sv
module bus_xfer_wdog
  import wdog_pkg::*;
#(
  parameter int LIMIT       = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_ni,
  input  logic tclk_i,
  input  logic clear_i,
  output logic fault_o
);
  logic             strobe_q;
  logic             strobe_fall, strobe_rise;
  logic             tick, expire;
  logic [CNT_W-1:0] cnt;
  wd_state_e        state;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b1;
    else         strobe_q <= strobe_ni;
  end

  assign strobe_fall = strobe_q & ~strobe_ni;
  assign strobe_rise = ~strobe_q & strobe_ni;

  wdog_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(tclk_i),
    .fall_o (tick)
  );

  wdog_timer #(.LIMIT(LIMIT)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (strobe_fall),
    .done_i  (strobe_rise),
    .low_i   (~strobe_ni),
    .tick_i  (tick),
    .expire_o(expire),
    .cnt_o   (cnt),
    .state_o (state)
  );

  wdog_fault_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (expire),
    .clear_i(clear_i),
    .flag_o (fault_o)
  );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
#(
  parameter int LIMIT = 2,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             strobe_ni,
  input logic             clear_i,
  input logic             fault_o,
  input logic [CNT_W-1:0] cnt,
  input wd_state_e        state
);
  a_r9_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(LIMIT));

  a_r5_high_strobe_zero_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_ni |=> (cnt == '0));

  a_r8_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !clear_i) |=> fault_o);

  a_r8_clear_wins_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && strobe_ni) |=> !fault_o);

  a_r7_rise_needs_low_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_o && strobe_ni) |=> !fault_o);

  a_r9_spent_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == WD_SPENT && !strobe_ni) |=> (state == WD_SPENT));
endmodule

bind bus_xfer_wdog wdog_checker #(.LIMIT(LIMIT)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .strobe_ni(strobe_ni),
  .clear_i  (clear_i),
  .fault_o  (fault_o),
  .cnt      (cnt),
  .state    (state)
);

// File: tb/sim_bus_xfer_wdog.sv
module sim_bus_xfer_wdog;
  localparam int LIMIT = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic strobe_ni = 1'b1;
  logic tclk_i = 1'b1;
  logic clear_i = 1'b0;
  logic fault_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_xfer_wdog #(.LIMIT(LIMIT)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .strobe_ni(strobe_ni),
    .tclk_i(tclk_i), .clear_i(clear_i), .fault_o(fault_o)
  );

  task automatic chk(input string req, input logic exp);
    checks++;
    if (fault_o !== exp) begin
      errors++;
      $display("FAIL %s fault_o=%b expected=%b", req, fault_o, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tfall();
    tclk_i = 1'b0; cyc(4);
    tclk_i = 1'b1; cyc(4);
  endtask

  task automatic clr();
    clear_i = 1'b1; cyc(1);
    clear_i = 1'b0; cyc(1);
  endtask

  task automatic xfer_start();
    strobe_ni = 1'b0; cyc(2);
  endtask

  task automatic xfer_end();
    strobe_ni = 1'b1; cyc(3);
  endtask

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(3);
    chk("R1", 1'b0);

    // R3 R4: sweep the number of timer edges inside one transfer
    for (int k = 0; k <= 4; k++) begin
      xfer_start();
      for (int e = 0; e < k; e++) tfall();
      cyc(2);
      chk(k >= LIMIT ? "R4" : "R3", (k >= LIMIT) ? 1'b1 : 1'b0);
      xfer_end();
      chk("R8", (k >= LIMIT) ? 1'b1 : 1'b0);
      clr();
      chk("R8", 1'b0);
    end

    // R6: edges while the strobe is high are ignored
    for (int e = 0; e < 3; e++) tfall();
    chk("R6", 1'b0);
    xfer_start(); tfall(); cyc(2);
    chk("R6", 1'b0);
    xfer_end();

    // R5: a completed transfer restarts the count
    xfer_start(); tfall(); xfer_end();
    xfer_start(); tfall(); cyc(2);
    chk("R5", 1'b0);
    tfall(); cyc(2);
    chk("R5", 1'b1);

    // R9: no restart after expiry until the strobe rises and falls
    clr();
    for (int e = 0; e < 3; e++) tfall();
    chk("R9", 1'b0);
    xfer_end();
    clr();

    // R2 R7: release offset d after the expiring timer edge is driven
    for (int d = 0; d <= 5; d++) begin
      xfer_start(); tfall(); cyc(2);
      tclk_i = 1'b0;
      cyc(d);
      strobe_ni = 1'b1;
      cyc(4);
      chk(d == 2 ? "R7" : "R2", (d >= 3) ? 1'b1 : 1'b0);
      tclk_i = 1'b1; cyc(4);
      clr();
    end

    // R8: expiry in the same cycle as a clear keeps the fault
    xfer_start(); tfall(); cyc(2);
    tclk_i = 1'b0; cyc(2);
    clear_i = 1'b1; cyc(1);
    clear_i = 1'b0; cyc(1);
    chk("R8", 1'b1);
    tclk_i = 1'b1; cyc(2);
    xfer_end(); clr();
    chk("R8", 1'b0);

    // R1: reset clears a set fault
    xfer_start(); tfall(); tfall(); cyc(2);
    chk("R4", 1'b1);
    rst_ni = 1'b0; cyc(2);
    chk("R1", 1'b0);
    strobe_ni = 1'b1; rst_ni = 1'b1; cyc(2);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog timeout actual=running expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule